// File: doc/BRIEF.md
# Burst Radix-2 In-Place FFT

This block computes a fixed-point discrete Fourier transform of a compile-time power-of-two length with as little arithmetic as possible. The transform is X[k] = sum over n of x[n]·e^(-j·2πnk/N). A frame of N complex samples is written into an internal sample memory. One radix-2 decimation-in-frequency butterfly, which has a single complex twiddle multiplier, then works through the memory log2(N) times, and each result goes back to the two locations its operands came from. When the last pass is done, the memory is streamed out one bin per cycle. The block cycles through three phases: fill, crunch and emit.

Input samples use a valid/ready handshake. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. While a frame is being transformed or emitted, the block holds `in_ready` low and ignores anything on the input. The output has no back-pressure: `out_valid` stays high for N consecutive cycles, with `out_start` and `out_end` marking the first and last bin. There are two options. One divides each butterfly output by two, giving an overall 1/N gain. The other reads the memory through reversed addresses so the bins come out in natural order. A synchronous `clr` drops any frame in progress.

Top module: `fft_burst_r2`

## Requirements
- R1: A sample (`in_re`, `in_im`, two's complement) is stored only on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 after reset and stays 1 until N samples have been stored. Gaps in `in_valid` during the fill phase do not change the result.
- R2: From the cycle after the Nth sample is stored until the last output cycle, `in_ready` is 0. Any `in_valid` or data driven in that period has no effect on the result.
- R3: With SCALE=1, the output bin k equals X[k]/N. Each butterfly sum and each rotated difference is arithmetically shifted right by one bit (truncation toward minus infinity). Twiddle factors are rounded to TW_W bits, with 1.0 = 2^(TW_W-2).
- R4: With SCALE=0, no shift is applied. The output width is DATA_W+LOG2N, and the output bin k equals X[k].
- R5: With LINEAR_OUT=0, output position m (counted from 0 at `out_start`) carries bin bitrev(m), where bitrev reverses the LOG2N-bit index. With LINEAR_OUT=1, position m carries bin m.
- R6: Each frame gives exactly N consecutive cycles with `out_valid`=1. `out_start` is 1 only in the first of these cycles and `out_end` only in the last. `out_valid` is 0 in the cycle after `out_end`.
- R7: The first `out_valid` appears LOG2N·(N/2+1)+1 rising edges after the edge that stores the Nth sample.
- R8: `clr`=1 at a rising edge abandons the current frame and any partial fill. After that edge, `in_ready` is 1 and `out_valid` is 0, and the next frame is stored starting from sample 0.
- R9: `in_ready` returns to 1 in the same cycle that `out_end` is 1, so the next frame can begin while the last bin is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous frame abort |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block is filling and can take a sample |
| in_re | input | DATA_W | Real part of input sample, signed |
| in_im | input | DATA_W | Imaginary part of input sample, signed |
| out_valid | output | 1 | Output bin is valid |
| out_start | output | 1 | First bin of a frame |
| out_end | output | 1 | Last bin of a frame |
| out_re | output | DATA_W (+LOG2N if SCALE=0) | Real part of output bin, signed |
| out_im | output | DATA_W (+LOG2N if SCALE=0) | Imaginary part of output bin, signed |

## Verification
Two functions can fall in the same cycle. The last bin of one frame is presented while `in_ready` has already risen for the next frame, so the emit and fill phases share that cycle. The bench samples `in_ready` in the `out_end` cycle of every frame and requires it to be 1. It also requires `in_ready` to be 0 in the `out_start` cycle. A clear that lands mid-fill, and another that lands mid-crunch, make abort compete with loading and with butterfly write-back. In each case the next frame must come out bit-exact and with the documented latency.

// File: rtl/fft_pkg.sv
package fft_pkg;

  typedef enum logic [1:0] {
    PH_FILL   = 2'd0,
    PH_CRUNCH = 2'd1,
    PH_EMIT   = 2'd2
  } phase_e;

  // Fixed-point twiddle: cos or -sin of 2*pi*k/n, unity at 2^(tw_w-2)
  function automatic int tw_fix(int k, int n, int tw_w, bit sine);
    real ang;
    real v;
    real one;
    ang = 6.283185307179586 * real'(k) / real'(n);
    v   = sine ? -$sin(ang) : $cos(ang);
    one = 2.0 ** (tw_w - 2);
    return $rtoi(v * one + ((v < 0.0) ? -0.5 : 0.5));
  endfunction

endpackage

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
  parameter int LOG2N = 3,
  parameter int PCW   = 2
) (
  input  logic [PCW-1:0]   pass_i,
  input  logic [LOG2N-2:0] bfly_i,
  output logic [LOG2N-1:0] addr_a_o,
  output logic [LOG2N-1:0] addr_b_o,
  output logic [LOG2N-2:0] tw_idx_o
);

  // Pass p pairs addresses that differ in bit (LOG2N-1-p).
  always_comb begin
    int hb;
    logic [LOG2N-1:0] j;
    logic [LOG2N-1:0] low;
    logic [LOG2N-1:0] high;
    logic [LOG2N-1:0] mask;
    logic [LOG2N-1:0] tw_w;
    hb       = LOG2N - 1 - int'(pass_i);
    j        = {1'b0, bfly_i};
    mask     = (LOG2N'(1) << hb) - LOG2N'(1);
    low      = j & mask;
    high     = j >> hb;
    addr_a_o = (high << (hb + 1)) | low;
    addr_b_o = addr_a_o | (LOG2N'(1) << hb);
    tw_w     = low << pass_i;
    tw_idx_o = tw_w[LOG2N-2:0];
  end

endmodule

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
  parameter int LOG2N = 3,
  parameter int TW_W  = 18
) (
  input  logic        [LOG2N-2:0] idx_i,
  output logic signed [TW_W-1:0]  w_re_o,
  output logic signed [TW_W-1:0]  w_im_o
);
  import fft_pkg::*;

  localparam int N    = 1 << LOG2N;
  localparam int HALF = N / 2;

  logic signed [TW_W-1:0] tab_re [HALF];
  logic signed [TW_W-1:0] tab_im [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_tw
    localparam logic signed [TW_W-1:0] C_RE = TW_W'(tw_fix(k, N, TW_W, 1'b0));
    localparam logic signed [TW_W-1:0] C_IM = TW_W'(tw_fix(k, N, TW_W, 1'b1));
    assign tab_re[k] = C_RE;
    assign tab_im[k] = C_IM;
  end

  assign w_re_o = tab_re[idx_i];
  assign w_im_o = tab_im[idx_i];

endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly #(
  parameter int IW    = 16,
  parameter int TW_W  = 18,
  parameter int SCALE = 1
) (
  input  logic signed [IW-1:0]   a_re,
  input  logic signed [IW-1:0]   a_im,
  input  logic signed [IW-1:0]   b_re,
  input  logic signed [IW-1:0]   b_im,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  output logic signed [IW-1:0]   t_re,
  output logic signed [IW-1:0]   t_im,
  output logic signed [IW-1:0]   u_re,
  output logic signed [IW-1:0]   u_im
);

  localparam int PW = IW + TW_W + 2;
  localparam int SH = TW_W - 2;

  logic signed [IW:0]   s_re, s_im, d_re, d_im, r_re, r_im;
  logic signed [PW-1:0] dre_x, dim_x, wre_x, wim_x, p_re, p_im;

  always_comb begin
    s_re  = (IW+1)'(a_re) + (IW+1)'(b_re);
    s_im  = (IW+1)'(a_im) + (IW+1)'(b_im);
    d_re  = (IW+1)'(a_re) - (IW+1)'(b_re);
    d_im  = (IW+1)'(a_im) - (IW+1)'(b_im);
    dre_x = PW'(d_re);
    dim_x = PW'(d_im);
    wre_x = PW'(w_re);
    wim_x = PW'(w_im);
    p_re  = dre_x * wre_x - dim_x * wim_x;
    p_im  = dre_x * wim_x + dim_x * wre_x;
    r_re  = (IW+1)'(p_re >>> SH);
    r_im  = (IW+1)'(p_im >>> SH);
  end

  if (SCALE != 0) begin : g_half
    assign t_re = IW'(s_re >>> 1);
    assign t_im = IW'(s_im >>> 1);
    assign u_re = IW'(r_re >>> 1);
    assign u_im = IW'(r_im >>> 1);
  end else begin : g_grow
    assign t_re = IW'(s_re);
    assign t_im = IW'(s_im);
    assign u_re = IW'(r_re);
    assign u_im = IW'(r_im);
  end

endmodule

// File: rtl/fft_burst_r2.sv
module fft_burst_r2 #(
  parameter int LOG2N      = 3,
  parameter int DATA_W     = 16,
  parameter int TW_W       = 18,
  parameter int SCALE      = 1,
  parameter int LINEAR_OUT = 0,
  localparam int OW        = DATA_W + ((SCALE != 0) ? 0 : LOG2N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic                     out_start,
  output logic                     out_end,
  output logic signed [OW-1:0]     out_re,
  output logic signed [OW-1:0]     out_im
);
  import fft_pkg::*;

  localparam int N    = 1 << LOG2N;
  localparam int HALF = N / 2;
  localparam int AW   = LOG2N;
  localparam int IW   = OW;
  localparam int PCW  = $clog2(LOG2N + 1);

  phase_e            state_q;
  logic [AW-1:0]     fill_q, emit_q, bf_q;
  logic [PCW-1:0]    pass_q;
  logic              take, bf_last, pass_last;

  logic signed [IW-1:0] mem_re [N];
  logic signed [IW-1:0] mem_im [N];

  // Address generation and twiddle lookup for the current butterfly
  logic [AW-1:0]          ag_a, ag_b;
  logic [AW-2:0]          ag_tw;
  logic signed [TW_W-1:0] rom_re, rom_im;

  fft_addr_gen #(.LOG2N(LOG2N), .PCW(PCW)) u_agen (
    .pass_i   (pass_q),
    .bfly_i   (bf_q[AW-2:0]),
    .addr_a_o (ag_a),
    .addr_b_o (ag_b),
    .tw_idx_o (ag_tw)
  );

  fft_twiddle_rom #(.LOG2N(LOG2N), .TW_W(TW_W)) u_rom (
    .idx_i  (ag_tw),
    .w_re_o (rom_re),
    .w_im_o (rom_im)
  );

  // Operand register stage between memory read and write-back
  logic                   s1_v;
  logic [AW-1:0]          s1_aa, s1_ab;
  logic signed [IW-1:0]   s1_a_re, s1_a_im, s1_b_re, s1_b_im;
  logic signed [TW_W-1:0] s1_w_re, s1_w_im;
  logic signed [IW-1:0]   bt_t_re, bt_t_im, bt_u_re, bt_u_im;

  fft_butterfly #(.IW(IW), .TW_W(TW_W), .SCALE(SCALE)) u_bfly (
    .a_re (s1_a_re), .a_im (s1_a_im),
    .b_re (s1_b_re), .b_im (s1_b_im),
    .w_re (s1_w_re), .w_im (s1_w_im),
    .t_re (bt_t_re), .t_im (bt_t_im),
    .u_re (bt_u_re), .u_im (bt_u_im)
  );

  assign in_ready  = (state_q == PH_FILL);
  assign take      = in_valid && in_ready;
  assign bf_last   = (bf_q == AW'(HALF));
  assign pass_last = (pass_q == PCW'(LOG2N - 1));

  // Emit read address: plain or bit-reversed
  logic [AW-1:0] rd_addr;
  if (LINEAR_OUT != 0) begin : g_lin
    always_comb begin
      for (int i = 0; i < AW; i++) rd_addr[i] = emit_q[AW-1-i];
    end
  end else begin : g_rev
    assign rd_addr = emit_q;
  end

  // Phase control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_FILL;
      fill_q    <= '0;
      emit_q    <= '0;
      bf_q      <= '0;
      pass_q    <= '0;
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_end   <= 1'b0;
    end else if (clr) begin
      state_q   <= PH_FILL;
      fill_q    <= '0;
      emit_q    <= '0;
      bf_q      <= '0;
      pass_q    <= '0;
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_end   <= 1'b0;
    end else begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_end   <= 1'b0;
      case (state_q)
        PH_FILL: begin
          if (take) begin
            if (fill_q == AW'(N - 1)) begin
              fill_q  <= '0;
              bf_q    <= '0;
              pass_q  <= '0;
              state_q <= PH_CRUNCH;
            end else begin
              fill_q <= fill_q + AW'(1);
            end
          end
        end
        PH_CRUNCH: begin
          s1_v <= !bf_last;
          if (bf_last) begin
            bf_q <= '0;
            if (pass_last) begin
              emit_q  <= '0;
              state_q <= PH_EMIT;
            end else begin
              pass_q <= pass_q + PCW'(1);
            end
          end else begin
            bf_q <= bf_q + AW'(1);
          end
        end
        PH_EMIT: begin
          out_valid <= 1'b1;
          out_start <= (emit_q == '0);
          out_end   <= (emit_q == AW'(N - 1));
          emit_q    <= emit_q + AW'(1);
          if (emit_q == AW'(N - 1)) state_q <= PH_FILL;
        end
        default: state_q <= PH_FILL;
      endcase
    end
  end

  // Sample memory, operand stage and output data
  always_ff @(posedge clk) begin
    if (take) begin
      mem_re[fill_q] <= IW'(in_re);
      mem_im[fill_q] <= IW'(in_im);
    end
    if (s1_v) begin
      mem_re[s1_aa] <= bt_t_re;
      mem_im[s1_aa] <= bt_t_im;
      mem_re[s1_ab] <= bt_u_re;
      mem_im[s1_ab] <= bt_u_im;
    end
    s1_aa   <= ag_a;
    s1_ab   <= ag_b;
    s1_a_re <= mem_re[ag_a];
    s1_a_im <= mem_im[ag_a];
    s1_b_re <= mem_re[ag_b];
    s1_b_im <= mem_im[ag_b];
    s1_w_re <= rom_re;
    s1_w_im <= rom_im;
    out_re  <= mem_re[rd_addr];
    out_im  <= mem_im[rd_addr];
  end

  // R6
  start_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);
  // R6
  end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |=> !out_valid);
  // R2
  start_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> !in_ready);
  // R9
  end_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> in_ready);
  // R8
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_ready && !out_valid));
  // R3
  pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> (s1_aa != s1_ab));

endmodule

// File: tb/fft_burst_r2_bench.sv
module fft_burst_r2_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LOG2N  = 3;
  localparam int N      = 1 << LOG2N;
  localparam int DATA_W = 16;
  localparam int RAW_W  = DATA_W + LOG2N;
  localparam int LAT    = LOG2N * (N / 2 + 1) + 1;

  // Vector: [31:24] pattern, [23:16] noise while busy, [15:0] signed amplitude
  // pattern 0 real DC, 1 impulse at 0, 2 alternating sign, 3 imaginary DC, 4 impulse at N/2
  localparam int VEC_N = 6;
  localparam logic [31:0] VEC [VEC_N] = '{
    {8'd0, 8'd0, 16'd800},
    {8'd1, 8'd1, 16'd1600},
    {8'd2, 8'd0, 16'd400},
    {8'd3, 8'd1, 16'd480},
    {8'd4, 8'd0, 16'd1200},
    {8'd0, 8'd1, 16'hFC18}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_re = '0, in_im = '0;
  logic rdy_a, rdy_b, rdy_c;
  logic v_a, v_b, v_c, s_a, s_b, s_c, e_a, e_b, e_c;
  logic signed [DATA_W-1:0] re_a, im_a, re_b, im_b;
  logic signed [RAW_W-1:0]  re_c, im_c;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fft_burst_r2 #(.LOG2N(LOG2N), .DATA_W(DATA_W)) u_fft_burst_r2 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(rdy_a),
    .in_re(in_re), .in_im(in_im), .out_valid(v_a), .out_start(s_a), .out_end(e_a),
    .out_re(re_a), .out_im(im_a));

  fft_burst_r2 #(.LOG2N(LOG2N), .DATA_W(DATA_W), .LINEAR_OUT(1)) u_fft_lin (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(rdy_b),
    .in_re(in_re), .in_im(in_im), .out_valid(v_b), .out_start(s_b), .out_end(e_b),
    .out_re(re_b), .out_im(im_b));

  fft_burst_r2 #(.LOG2N(LOG2N), .DATA_W(DATA_W), .SCALE(0)) u_fft_raw (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(rdy_c),
    .in_re(in_re), .in_im(in_im), .out_valid(v_c), .out_start(s_c), .out_end(e_c),
    .out_re(re_c), .out_im(im_c));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int brev(int m);
    int r = 0;
    for (int i = 0; i < LOG2N; i++) if (m[i]) r |= 1 << (LOG2N - 1 - i);
    return r;
  endfunction

  function automatic int gen_re(int pat, int amp, int n);
    case (pat)
      0: return amp;
      1: return (n == 0) ? amp : 0;
      2: return (n % 2 == 0) ? amp : -amp;
      4: return (n == N / 2) ? amp : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int gen_im(int pat, int amp);
    return (pat == 3) ? amp : 0;
  endfunction

  // Expected bin k, scaled by 1/N
  function automatic int exp_re(int pat, int amp, int k);
    case (pat)
      0: return (k == 0) ? amp : 0;
      1: return amp / N;
      2: return (k == N / 2) ? amp : 0;
      4: return (k % 2 == 0) ? amp / N : -(amp / N);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_im(int pat, int amp, int k);
    return (pat == 3 && k == 0) ? amp : 0;
  endfunction

  task automatic load_frame(input int pat, input int amp, input bit gaps);
    for (int n = 0; n < N; n++) begin
      if (gaps) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_re = 16'sd1234;
        in_im = -16'sd777;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_re = DATA_W'(gen_re(pat, amp, n));
      in_im = DATA_W'(gen_im(pat, amp));
    end
    @(posedge clk);
  endtask

  task automatic run_frame(input int pat, input int amp, input bit noise, input bit gaps);
    int lat = 0;
    bit got = 0;
    bit saw_ready = 0;
    load_frame(pat, amp, gaps);
    while (!got && lat < 1000) begin
      @(negedge clk);
      if (v_a) begin
        got = 1;
        in_valid = 1'b0;
      end else begin
        if (rdy_a) saw_ready = 1;
        in_valid = noise;
        in_re = 16'sd3000 + DATA_W'(lat);
        in_im = -16'sd2500;
        @(posedge clk);
        lat++;
      end
    end
    chk(lat == LAT, "R7 latency", lat, LAT);
    chk(!saw_ready, "R2 ready low while busy", saw_ready, 0);
    for (int m = 0; m < N; m++) begin
      int kb;
      if (m > 0) @(negedge clk);
      kb = brev(m);
      chk(v_a && v_b && v_c, "R6 valid run", m, N);
      chk(s_a == (m == 0) && s_b == (m == 0), "R6 start flag", s_a, m == 0);
      chk(e_a == (m == N - 1) && e_c == (m == N - 1), "R6 end flag", e_a, m == N - 1);
      chk(int'(re_a) == exp_re(pat, amp, kb) && int'(im_a) == exp_im(pat, amp, kb),
          "R3 R5 bit-reversed bin", int'(re_a), exp_re(pat, amp, kb));
      chk(int'(re_b) == exp_re(pat, amp, m) && int'(im_b) == exp_im(pat, amp, m),
          "R5 linear bin", int'(re_b), exp_re(pat, amp, m));
      chk(int'(re_c) == N * exp_re(pat, amp, kb) && int'(im_c) == N * exp_im(pat, amp, kb),
          "R4 unscaled bin", int'(re_c), N * exp_re(pat, amp, kb));
      if (m == 0) chk(!rdy_a, "R2 ready low at start", rdy_a, 0);
      if (m == N - 1) chk(rdy_a && rdy_b && rdy_c, "R9 ready with end", rdy_a, 1);
    end
    @(negedge clk);
    chk(!v_a && !v_b && !v_c, "R6 valid drops after end", v_a, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R8 reset state
    chk(rdy_a && rdy_b && rdy_c, "R8 reset: no ready", rdy_a, 1);
    chk(!v_a && !v_b && !v_c, "R8 reset: valid set", v_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_a, "R1 ready after reset", rdy_a, 1);

    // Vector table
    for (int i = 0; i < VEC_N; i++) begin
      run_frame(int'(VEC[i][31:24]), int'($signed(VEC[i][15:0])), VEC[i][16], 1'b0);
    end

    // R1: bubbles in in_valid during fill
    run_frame(1, 800, 1'b0, 1'b1);

    // R8: clear during a partial fill
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = 16'sd5000;
      in_im = 16'sd5000;
    end
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(rdy_a && !v_a, "R8 clear mid-fill", rdy_a, 1);
    run_frame(2, -800, 1'b0, 1'b0);

    // R8: clear while crunching
    load_frame(3, 960, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(!rdy_a, "R2 busy before clear", rdy_a, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(rdy_a && !v_a, "R8 clear mid-crunch", rdy_a, 1);
    run_frame(0, 640, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule